// File: doc/BRIEF.md
# Dual-Channel Register Access Decoder

This block sits between a host's byte-wide register bus and the two register banks of a two-channel serial controller. A host cycle carries an active-low chip select, a channel-select line, a register address, read and write strobes and a data byte. The decoder chooses the target channel and turns each rising edge of the write strobe into a one-cycle, registered write enable for that channel's bank. Address and data are registered alongside the enable. On reads it returns the selected channel's data together with an output-enable flag.

Each channel also owns a small alternate-function register that is held inside this block. Bit 0 of that register is the broadcast enable. When the copy that belongs to the currently selected channel has this bit set, a write goes to both channels in the same cycle. This lets software initialise both channels with a single pass over the registers. Reads are never broadcast. They always follow the channel-select line.

The serial engines, FIFOs and flow control sit behind the bank ports and are not part of this block. Those banks keep their own reset defaults.

Top module: `dual_chan_reg_decoder`

## Requirements
- R1: After reset, both write enables are 0 and both alternate-function registers read back as 0x00, so broadcast is off.
- R2: While `cs_n` is 1, no write enable pulses, no alternate-function register changes, `rdata_oe` is 0 and `rdata` is 0x00.
- R3: With `cs_n` 0, `chan_sel` 1 and broadcast off, a write goes to channel A only (`wr_en_a`).
- R4: With `cs_n` 0, `chan_sel` 0 and broadcast off, a write goes to channel B only (`wr_en_b`).
- R5: When bit 0 of the selected channel's alternate-function register is 1, a write reaches both channels. This holds both for bank writes, where both enables pulse, and for writes to the alternate-function address, where both copies load.
- R6: A read with `cs_n` 0 and `rd_stb` 1 sets `rdata_oe`. It returns `rd_data_a` when `chan_sel` is 1 and `rd_data_b` when `chan_sel` is 0, whatever the broadcast setting.
- R7: The broadcast enable is taken only from the copy that belongs to the channel named by `chan_sel`. The other channel's bit 0 has no effect on that write.
- R8: Each rising edge of `wr_stb` under chip select gives exactly one enable pulse, one clock cycle long, in the cycle after the edge on which the strobe is first seen high. `wr_addr` and `wr_data` carry the cycle's address and data during that pulse. A strobe held high does not repeat the pulse.
- R9: The alternate-function register sits at address `AFR_ADDR` (default 0xF). Writes to it pulse neither bank enable, and reads of it return this block's copy for the selected channel instead of bank data.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| cs_n | input | 1 | Chip select, active low |
| chan_sel | input | 1 | 1 selects channel A, 0 selects channel B |
| addr | input | ADDR_W | Register address |
| rd_stb | input | 1 | Read strobe, active high |
| wr_stb | input | 1 | Write strobe, active high |
| wdata | input | DATA_W | Write data from host |
| rd_data_a | input | DATA_W | Read data from channel A bank |
| rd_data_b | input | DATA_W | Read data from channel B bank |
| rdata | output | DATA_W | Read data to host |
| rdata_oe | output | 1 | Read data valid/drive enable |
| wr_en_a | output | 1 | One-cycle write enable, channel A bank |
| wr_en_b | output | 1 | One-cycle write enable, channel B bank |
| wr_addr | output | ADDR_W | Registered write address to banks |
| wr_data | output | DATA_W | Registered write data to banks |

## Verification
Write enables, `wr_addr` and `wr_data` are due one clock after the edge at which the strobe is first sampled high. The bench drives each write on a falling edge, lets one rising edge pass and samples on the next falling edge. It then samples again one cycle later to confirm the pulse has ended. Read data and `rdata_oe` are combinational, so they are checked 1 ns after the inputs change, in the same cycle. An alternate-function write becomes visible to reads from the cycle after its edge, and the bench reads it back only after that edge.

// File: rtl/dcd_pkg.sv
package dcd_pkg;

  // index 0 = channel A, index 1 = channel B
  localparam int NUM_CH = 2;
  localparam int CH_A   = 0;
  localparam int CH_B   = 1;

  // Channel mask of the banks a write reaches.
  function automatic logic [NUM_CH-1:0] dcd_targets(input logic cs_n,
                                                    input logic chan_sel,
                                                    input logic bcast);
    logic [NUM_CH-1:0] m;
    m = '0;
    if (!cs_n) begin
      if (bcast)         m = '1;
      else if (chan_sel) m[CH_A] = 1'b1;
      else               m[CH_B] = 1'b1;
    end
    return m;
  endfunction

endpackage

// File: rtl/dcd_afr_bank.sv
module dcd_afr_bank #(
  parameter int DATA_W = 8
) (
  input  logic                           clk,
  input  logic                           rst_n,
  input  logic [dcd_pkg::NUM_CH-1:0]     we,
  input  logic [DATA_W-1:0]              wdata,
  output logic [dcd_pkg::NUM_CH-1:0][DATA_W-1:0] afr
);
  for (genvar c = 0; c < dcd_pkg::NUM_CH; c++) begin : g_ch
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)     afr[c] <= '0;
      else if (we[c]) afr[c] <= wdata;
    end

    // R1: register holds reset default until written
    a_r1_afr_hold: assert property (@(posedge clk) disable iff (!rst_n)
      !we[c] |=> $stable(afr[c]));
  end
endmodule

// File: rtl/dcd_wr_fanout.sv
module dcd_wr_fanout #(
  parameter int ADDR_W = 4,
  parameter int DATA_W = 8
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       wr_rise,
  input  logic                       is_afr,
  input  logic [dcd_pkg::NUM_CH-1:0] targets,
  input  logic [ADDR_W-1:0]          addr,
  input  logic [DATA_W-1:0]          wdata,
  output logic                       wr_en_a,
  output logic                       wr_en_b,
  output logic [ADDR_W-1:0]          wr_addr,
  output logic [DATA_W-1:0]          wr_data
);
  logic bank_go;
  assign bank_go = wr_rise & ~is_afr;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_en_a <= 1'b0;
      wr_en_b <= 1'b0;
      wr_addr <= '0;
      wr_data <= '0;
    end else begin
      wr_en_a <= bank_go & targets[dcd_pkg::CH_A];
      wr_en_b <= bank_go & targets[dcd_pkg::CH_B];
      if (wr_rise) begin
        wr_addr <= addr;
        wr_data <= wdata;
      end
    end
  end

  // R8: a pulse never lasts beyond one cycle
  a_r8_single_cycle_a: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en_a |=> !wr_en_a);
  a_r8_single_cycle_b: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en_b |=> !wr_en_b);
  // R9: accesses to the alternate-function address never reach a bank
  a_r9_afr_no_bank: assert property (@(posedge clk) disable iff (!rst_n)
    is_afr |=> !wr_en_a && !wr_en_b);
endmodule

// File: rtl/dcd_rd_mux.sv
module dcd_rd_mux #(
  parameter int DATA_W = 8
) (
  input  logic                                   cs_n,
  input  logic                                   rd_stb,
  input  logic                                   chan_sel,
  input  logic                                   is_afr,
  input  logic [DATA_W-1:0]                      rd_data_a,
  input  logic [DATA_W-1:0]                      rd_data_b,
  input  logic [dcd_pkg::NUM_CH-1:0][DATA_W-1:0] afr,
  output logic [DATA_W-1:0]                      rdata,
  output logic                                   rdata_oe
);
  logic [DATA_W-1:0] bank_q;
  logic [DATA_W-1:0] sel_q;

  always_comb begin
    bank_q   = chan_sel ? rd_data_a : rd_data_b;
    sel_q    = is_afr ? afr[chan_sel ? dcd_pkg::CH_A : dcd_pkg::CH_B] : bank_q;
    rdata_oe = ~cs_n & rd_stb;
    rdata    = rdata_oe ? sel_q : '0;
  end

  // R2: nothing driven while deselected
  always_comb begin
    a_r2_rd_quiet: assert (!(cs_n && (rdata_oe || rdata != '0)) || $isunknown(cs_n));
  end
endmodule

// File: rtl/dual_chan_reg_decoder.sv
module dual_chan_reg_decoder #(
  parameter int               ADDR_W   = 4,
  parameter int               DATA_W   = 8,
  parameter logic [ADDR_W-1:0] AFR_ADDR = '1,
  parameter int               BCAST_BIT = 0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cs_n,
  input  logic              chan_sel,
  input  logic [ADDR_W-1:0] addr,
  input  logic              rd_stb,
  input  logic              wr_stb,
  input  logic [DATA_W-1:0] wdata,
  input  logic [DATA_W-1:0] rd_data_a,
  input  logic [DATA_W-1:0] rd_data_b,
  output logic [DATA_W-1:0] rdata,
  output logic              rdata_oe,
  output logic              wr_en_a,
  output logic              wr_en_b,
  output logic [ADDR_W-1:0] wr_addr,
  output logic [DATA_W-1:0] wr_data
);
  import dcd_pkg::*;

  logic                          wr_q;
  logic                          wr_rise;
  logic                          is_afr;
  logic                          bcast;
  logic [NUM_CH-1:0]             targets;
  logic [NUM_CH-1:0]             afr_we;
  logic [NUM_CH-1:0][DATA_W-1:0] afr;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) wr_q <= 1'b0;
    else        wr_q <= wr_stb;
  end

  assign wr_rise = wr_stb & ~wr_q & ~cs_n;
  assign is_afr  = (addr == AFR_ADDR);
  assign bcast   = afr[chan_sel ? CH_A : CH_B][BCAST_BIT];
  assign targets = dcd_targets(cs_n, chan_sel, bcast);
  assign afr_we  = targets & {NUM_CH{wr_rise & is_afr}};

  dcd_afr_bank #(.DATA_W(DATA_W)) i_afr (
    .clk, .rst_n, .we(afr_we), .wdata, .afr
  );

  dcd_wr_fanout #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) i_fan (
    .clk, .rst_n, .wr_rise, .is_afr, .targets, .addr, .wdata,
    .wr_en_a, .wr_en_b, .wr_addr, .wr_data
  );

  dcd_rd_mux #(.DATA_W(DATA_W)) i_rd (
    .cs_n, .rd_stb, .chan_sel, .is_afr, .rd_data_a, .rd_data_b, .afr,
    .rdata, .rdata_oe
  );

  // R2: deselected cycles write nothing
  a_r2_no_write_deselected: assert property (@(posedge clk) disable iff (!rst_n)
    cs_n |=> !wr_en_a && !wr_en_b);
  // R3: channel A only without broadcast
  a_r3_chan_a_only: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_rise && !is_afr && chan_sel && !bcast) |=> wr_en_a && !wr_en_b);
  // R4: channel B only without broadcast
  a_r4_chan_b_only: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_rise && !is_afr && !chan_sel && !bcast) |=> !wr_en_a && wr_en_b);
  // R5: broadcast reaches both banks
  a_r5_broadcast_both: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_rise && !is_afr && bcast) |=> wr_en_a && wr_en_b);
  // R8: a held strobe produces no further pulse
  a_r8_held_no_repeat: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_q && wr_stb) |=> !wr_en_a && !wr_en_b);
  // R6: read follows chan_sel for bank addresses
  a_r6_read_follows_sel: assert property (@(posedge clk) disable iff (!rst_n)
    (rdata_oe && !is_afr) |-> rdata == (chan_sel ? rd_data_a : rd_data_b));
endmodule

// File: tb/test_dual_chan_reg_decoder.sv
`timescale 1ns/1ps
module test_dual_chan_reg_decoder;
  localparam int AW = 4;
  localparam int DW = 8;
  localparam logic [AW-1:0] AFR = 4'hF;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cs_n = 1'b1, chan_sel = 1'b0, rd_stb = 1'b0, wr_stb = 1'b0;
  logic [AW-1:0] addr = '0;
  logic [DW-1:0] wdata = '0, rd_data_a = '0, rd_data_b = '0;
  logic [DW-1:0] rdata, wr_data;
  logic [AW-1:0] wr_addr;
  logic rdata_oe, wr_en_a, wr_en_b;

  int checks = 0, fails = 0;
  logic [DW-1:0] m_afr_a = '0, m_afr_b = '0;

  always #2.5 clk = ~clk;

  dual_chan_reg_decoder #(.ADDR_W(AW), .DATA_W(DW), .AFR_ADDR(AFR)) i_dual_chan_reg_decoder (
    .clk, .rst_n, .cs_n, .chan_sel, .addr, .rd_stb, .wr_stb, .wdata,
    .rd_data_a, .rd_data_b, .rdata, .rdata_oe, .wr_en_a, .wr_en_b,
    .wr_addr, .wr_data
  );

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  // expected {b,a} enable pattern for a write
  function automatic logic [1:0] exp_mask(logic sel, logic desel);
    logic bc;
    bc = sel ? m_afr_a[0] : m_afr_b[0];
    if (desel) return 2'b00;
    if (bc)    return 2'b11;
    return sel ? 2'b01 : 2'b10;
  endfunction

  task automatic do_write(string req, logic desel, logic sel,
                          logic [AW-1:0] a, logic [DW-1:0] d);
    logic [1:0] m;
    m = exp_mask(sel, desel);
    @(negedge clk);
    cs_n = desel; chan_sel = sel; addr = a; wdata = d; wr_stb = 1'b1;
    @(negedge clk);
    wr_stb = 1'b0; cs_n = 1'b1;
    if (a == AFR) begin
      chk({req, " afr bank quiet R9"}, {wr_en_b, wr_en_a}, 2'b00);
      if (m[0]) m_afr_a = d;
      if (m[1]) m_afr_b = d;
    end else begin
      chk(req, {wr_en_b, wr_en_a}, m);
      if (m != 2'b00) begin
        chk({req, " addr R8"}, wr_addr, a);
        chk({req, " data R8"}, wr_data, d);
      end
    end
    @(negedge clk);
    chk({req, " pulse ends R8"}, {wr_en_b, wr_en_a}, 2'b00);
  endtask

  task automatic do_read(string req, logic desel, logic sel, logic [AW-1:0] a);
    logic [DW-1:0] e;
    @(negedge clk);
    cs_n = desel; chan_sel = sel; addr = a; rd_stb = 1'b1;
    rd_data_a = DW'($urandom); rd_data_b = DW'($urandom);
    #1;
    if (desel) e = '0;
    else if (a == AFR) e = sel ? m_afr_a : m_afr_b;
    else e = sel ? rd_data_a : rd_data_b;
    chk({req, " oe"}, rdata_oe, !desel);
    chk(req, rdata, e);
    rd_stb = 1'b0; cs_n = 1'b1;
  endtask

  initial begin : watchdog
    #400000;
    fails++;
    $display("FAIL watchdog: actual timeout expected finish");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    void'($urandom(32'h5EED_1234));
    repeat (3) @(negedge clk);
    chk("R1 enables", {wr_en_b, wr_en_a}, 2'b00);
    rst_n = 1'b1;
    do_read("R1 afr A", 1'b0, 1'b1, AFR);
    do_read("R1 afr B", 1'b0, 1'b0, AFR);

    do_write("R3 chan A", 1'b0, 1'b1, 4'h3, 8'hA5);
    do_write("R4 chan B", 1'b0, 1'b0, 4'h7, 8'h5A);
    do_write("R2 deselected", 1'b1, 1'b1, 4'h1, 8'h11);
    do_write("R2 deselected afr", 1'b1, 1'b1, AFR, 8'h01);
    do_read("R2 afr unchanged", 1'b0, 1'b1, AFR);
    do_read("R2 read deselected", 1'b1, 1'b0, 4'h2);

    // R7: A's copy on, B's off; write via B goes to B only
    do_write("R7 set A bcast", 1'b0, 1'b1, AFR, 8'h01);
    do_write("R7 B ignores A bit", 1'b0, 1'b0, 4'h4, 8'h44);
    do_write("R5 broadcast via A", 1'b0, 1'b1, 4'h5, 8'h55);
    do_read("R6 read A under bcast", 1'b0, 1'b1, 4'h5);
    do_read("R6 read B under bcast", 1'b0, 1'b0, 4'h5);
    do_write("R5 broadcast afr write", 1'b0, 1'b1, AFR, 8'h81);
    do_read("R5 afr B loaded", 1'b0, 1'b0, AFR);
    do_write("R5 broadcast via B", 1'b0, 1'b0, 4'h2, 8'h22);
    do_write("R5 clear both", 1'b0, 1'b0, AFR, 8'h00);
    do_read("R9 afr A cleared", 1'b0, 1'b1, AFR);

    // R8: held strobe gives one pulse
    @(negedge clk);
    cs_n = 1'b0; chan_sel = 1'b1; addr = 4'h6; wdata = 8'h66; wr_stb = 1'b1;
    @(negedge clk);
    chk("R8 held first pulse", {wr_en_b, wr_en_a}, 2'b01);
    @(negedge clk);
    chk("R8 held no repeat", {wr_en_b, wr_en_a}, 2'b00);
    @(negedge clk);
    chk("R8 held still quiet", {wr_en_b, wr_en_a}, 2'b00);
    wr_stb = 1'b0; cs_n = 1'b1;
    @(negedge clk);

    for (int i = 0; i < 150; i++) begin
      logic desel, sel, isw;
      logic [AW-1:0] a;
      desel = ($urandom % 6) == 0;
      sel   = 1'($urandom);
      isw   = 1'($urandom);
      a     = ($urandom % 5 == 0) ? AFR : AW'($urandom % 15);
      if (isw) do_write("R3/R4/R5/R7 random write", desel, sel, a,
                        (a == AFR) ? DW'($urandom % 2) : DW'($urandom));
      else     do_read("R6/R9 random read", desel, sel, a);
    end

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule